// File: doc/BRIEF.md
# Planar Graphics Memory Write Path

This block turns one processor byte write into four simultaneous byte writes, one per bit plane of a planar graphics memory. It combines the processor byte, a rotation count, a per-plane constant colour value with its enables, a pixel bit mask, a plane enable mask, a logical function, and the four bytes last latched from the planes. The block registers the write data, the per-plane write enables, the address and a write strobe, and presents them on the clock edge after the request.

Four write modes choose where each plane's source data comes from and which bits are replaced. In every mode, bits that are not selected keep the value of the plane's latch. This is how a read-modify-write of eight packed pixels is done in one processor cycle. The plane memories, the latch loading and the read path are outside this block. Configuration arrives as plain inputs and is sampled together with the request.

Top module: `planar_wr_path`

## Requirements
- R1: While the reset is low at a clock edge, the strobe, the plane enables, the plane data and the address are all zero on the next cycle.
- R2: A request at a clock edge raises the strobe for exactly the next cycle, with the plane enables equal to the 4-bit plane mask sampled with the request (bit n enables plane n). A cycle with no request gives a low strobe and all enables zero.
- R3: The output address equals the request address, one cycle later.
- R4: In mode 0 (mode field value 0), the source byte for a plane is the processor byte rotated right by the 3-bit rotate count (0 means no rotation).
- R5: In mode 0, a plane whose constant-enable bit n is 1 uses constant bit n copied to all eight bits as its source instead of the rotated byte.
- R6: The logical function field combines source and latch before masking: 0 passes the source, 1 ANDs it with the latch, 2 ORs, and 3 XORs.
- R7: In modes 0, 2 and 3, each output bit is the function result where the effective mask bit is 1 and the latch bit where it is 0. In modes 0 and 2 the effective mask is the bit-mask input.
- R8: In mode 1, each enabled plane receives its own latch byte unchanged. The bit mask, the function and the processor byte have no effect.
- R9: In mode 2, plane n's source is bit n of the unrotated processor byte copied to all eight bits.
- R10: In mode 3, plane n's source is constant bit n copied to all eight bits, whatever the constant enables are. The effective mask is the bit-mask input ANDed with the rotated processor byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_wr | input | 1 | Byte write request for this cycle |
| cpu_addr | input | ADDR_W (16) | Plane byte address of the request |
| cpu_data | input | 8 | Processor write byte |
| cfg_wmode | input | 2 | Write mode, 0 to 3 |
| cfg_rot | input | 3 | Right-rotate count |
| cfg_const | input | 4 | Constant colour, one bit per plane |
| cfg_const_en | input | 4 | Constant enables for mode 0, one bit per plane |
| cfg_bitmask | input | 8 | Pixel bit mask |
| cfg_planemask | input | 4 | Plane write enables |
| cfg_func | input | 2 | Logical function: pass, AND, OR, XOR |
| latch_in | input | 32 | Plane latches, plane n in bits 8n+7..8n |
| pl_wdata | output | 32 | Plane write data, plane n in bits 8n+7..8n |
| pl_we | output | 4 | Plane write enables |
| pl_addr | output | ADDR_W (16) | Registered write address |
| pl_strobe | output | 1 | Write strobe, one cycle after the request |

## Verification
Two functions meet within one write in two places. In mode 0 with only some constant enables set, rotated planes and constant planes are produced in the same cycle. In mode 3, the rotation feeds the mask while the constant feeds the data. The bench covers both with directed writes that use partial constant enables, non-zero rotations and non-trivial functions and masks, then runs back-to-back random writes that change mode every cycle. A behavioural bit-loop model predicts every output on every clock and compares it with the design.

// File: rtl/planar_pkg.sv
// Package: shared types and the per-bit logical function for the planar
// write path. Assumes the function encoding pass/AND/OR/XOR = 0..3.
package planar_pkg;

    typedef enum logic [1:0] {
        WM_DIRECT = 2'd0,
        WM_LATCH  = 2'd1,
        WM_SPLAT  = 2'd2,
        WM_MASKED = 2'd3
    } wmode_e;

    typedef enum logic [1:0] {
        FN_PASS = 2'd0,
        FN_AND  = 2'd1,
        FN_OR   = 2'd2,
        FN_XOR  = 2'd3
    } func_e;

endpackage

// File: rtl/planar_rotator.sv
// Module: right rotation of one byte by a small count.
// Assumes the count is narrower than the data width; purely combinational.
module planar_rotator #(
    parameter int W  = 8,
    localparam int CW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [CW-1:0] amt,
    output logic [W-1:0]  dout
);
    logic [2*W-1:0] dbl;

    // Rotate by shifting a doubled copy and keeping the low half.
    always_comb begin
        dbl  = {din, din} >> amt;
        dout = dbl[W-1:0];
    end
endmodule

// File: rtl/planar_lane.sv
// Module: one plane's write datapath. Selects the source byte by mode,
// applies the logical function against the latch, then merges source and
// latch under the effective mask. Combinational; assumes the mode and
// function inputs are stable for the cycle.
module planar_lane
    import planar_pkg::*;
#(
    parameter int W = 8
) (
    input  wmode_e       wmode,
    input  func_e        func,
    input  logic [W-1:0] rot_byte,
    input  logic         splat_bit,
    input  logic         const_bit,
    input  logic         const_en,
    input  logic [W-1:0] bitmask,
    input  logic [W-1:0] latch,
    output logic [W-1:0] result
);
    logic [W-1:0] src;
    logic [W-1:0] alu;
    logic [W-1:0] eff_mask;

    // Pick the source byte and the effective mask for the active mode.
    always_comb begin
        src      = rot_byte;
        eff_mask = bitmask;
        case (wmode)
            WM_DIRECT: src = const_en ? {W{const_bit}} : rot_byte;
            WM_LATCH:  src = latch;
            WM_SPLAT:  src = {W{splat_bit}};
            WM_MASKED: begin
                src      = {W{const_bit}};
                eff_mask = bitmask & rot_byte;
            end
            default:   src = rot_byte;
        endcase
    end

    // Logical function between source and latch.
    always_comb begin
        case (func)
            FN_PASS: alu = src;
            FN_AND:  alu = src & latch;
            FN_OR:   alu = src | latch;
            FN_XOR:  alu = src ^ latch;
            default: alu = src;
        endcase
    end

    // Final merge; the latch-copy mode bypasses both function and mask.
    always_comb begin
        if (wmode == WM_LATCH) begin
            result = latch;
        end else begin
            result = (alu & eff_mask) | (latch & ~eff_mask);
        end
    end
endmodule

// File: rtl/planar_wr_path.sv
// Module: top of the planar memory write path. Rotates the processor byte
// once, runs one lane per plane, and registers data, enables, address and
// strobe one cycle after the request. Assumes configuration is sampled
// together with the request; synchronous active-low reset.
module planar_wr_path
    import planar_pkg::*;
#(
    parameter int PLANES = 4,
    parameter int W      = 8,
    parameter int ADDR_W = 16,
    localparam int CW    = $clog2(W),
    localparam int DW    = PLANES * W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [W-1:0]      cpu_data,
    input  logic [1:0]        cfg_wmode,
    input  logic [CW-1:0]     cfg_rot,
    input  logic [PLANES-1:0] cfg_const,
    input  logic [PLANES-1:0] cfg_const_en,
    input  logic [W-1:0]      cfg_bitmask,
    input  logic [PLANES-1:0] cfg_planemask,
    input  logic [1:0]        cfg_func,
    input  logic [DW-1:0]     latch_in,
    output logic [DW-1:0]     pl_wdata,
    output logic [PLANES-1:0] pl_we,
    output logic [ADDR_W-1:0] pl_addr,
    output logic              pl_strobe
);
    wmode_e       wmode;
    func_e        func;
    logic [W-1:0] rot_byte;
    logic [DW-1:0] lane_out;

    assign wmode = wmode_e'(cfg_wmode);
    assign func  = func_e'(cfg_func);

    planar_rotator #(.W(W)) u_rot (
        .din  (cpu_data),
        .amt  (cfg_rot),
        .dout (rot_byte)
    );

    // One datapath lane per plane.
    for (genvar p = 0; p < PLANES; p++) begin : g_lane
        planar_lane #(.W(W)) u_lane (
            .wmode     (wmode),
            .func      (func),
            .rot_byte  (rot_byte),
            .splat_bit (cpu_data[p % W]),
            .const_bit (cfg_const[p]),
            .const_en  (cfg_const_en[p]),
            .bitmask   (cfg_bitmask),
            .latch     (latch_in[p*W +: W]),
            .result    (lane_out[p*W +: W])
        );
    end

    // Strobe and plane enables follow the request by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pl_strobe <= 1'b0;
            pl_we     <= '0;
        end else begin
            pl_strobe <= cpu_wr;
            pl_we     <= cpu_wr ? cfg_planemask : '0;
        end
    end

    // Data and address capture on a request and hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pl_wdata <= '0;
            pl_addr  <= '0;
        end else if (cpu_wr) begin
            pl_wdata <= lane_out;
            pl_addr  <= cpu_addr;
        end
    end
endmodule

// File: rtl/planar_wr_path_chk.sv
// Module: assertion checker for the planar write path, bound to the top.
module planar_wr_path_chk #(
    parameter int PLANES = 4,
    parameter int W      = 8,
    parameter int ADDR_W = 16,
    localparam int DW    = PLANES * W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_wr,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [1:0]        cfg_wmode,
    input logic [W-1:0]      cfg_bitmask,
    input logic [PLANES-1:0] cfg_planemask,
    input logic [DW-1:0]     latch_in,
    input logic [DW-1:0]     pl_wdata,
    input logic [PLANES-1:0] pl_we,
    input logic [ADDR_W-1:0] pl_addr,
    input logic              pl_strobe
);
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!pl_strobe && pl_we == '0)); // R1
    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) cpu_wr |=> pl_strobe); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !cpu_wr |=> (!pl_strobe && pl_we == '0)); // R2
    AST_WE_MATCH: assert property (@(posedge clk) disable iff (!rst_n) cpu_wr |=> pl_we == $past(cfg_planemask)); // R2
    AST_ADDR_MATCH: assert property (@(posedge clk) disable iff (!rst_n) cpu_wr |=> pl_addr == $past(cpu_addr)); // R3
    AST_LATCH_COPY: assert property (@(posedge clk) disable iff (!rst_n) (cpu_wr && cfg_wmode == 2'd1) |=> pl_wdata == $past(latch_in)); // R8
    AST_MASK_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n) cpu_wr |=> ((pl_wdata ^ $past(latch_in)) & ~{PLANES{$past(cfg_bitmask)}}) == '0); // R7
endmodule

bind planar_wr_path planar_wr_path_chk #(
    .PLANES (PLANES),
    .W      (W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_wr        (cpu_wr),
    .cpu_addr      (cpu_addr),
    .cfg_wmode     (cfg_wmode),
    .cfg_bitmask   (cfg_bitmask),
    .cfg_planemask (cfg_planemask),
    .latch_in      (latch_in),
    .pl_wdata      (pl_wdata),
    .pl_we         (pl_we),
    .pl_addr       (pl_addr),
    .pl_strobe     (pl_strobe)
);

// File: tb/planar_wr_path_tb.sv
module planar_wr_path_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic [1:0]  cfg_wmode = '0;
    logic [2:0]  cfg_rot = '0;
    logic [3:0]  cfg_const = '0;
    logic [3:0]  cfg_const_en = '0;
    logic [7:0]  cfg_bitmask = '0;
    logic [3:0]  cfg_planemask = '0;
    logic [1:0]  cfg_func = '0;
    logic [31:0] latch_in = '0;
    logic [31:0] pl_wdata;
    logic [3:0]  pl_we;
    logic [15:0] pl_addr;
    logic        pl_strobe;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_data = '0;
    logic [15:0] exp_addr = '0;
    logic [3:0]  exp_we = '0;
    logic        exp_stb = 1'b0;
    string       cur_tag = "R1";

    always #4 clk = ~clk;

    planar_wr_path u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_data(cpu_data), .cfg_wmode(cfg_wmode), .cfg_rot(cfg_rot),
        .cfg_const(cfg_const), .cfg_const_en(cfg_const_en),
        .cfg_bitmask(cfg_bitmask), .cfg_planemask(cfg_planemask),
        .cfg_func(cfg_func), .latch_in(latch_in), .pl_wdata(pl_wdata),
        .pl_we(pl_we), .pl_addr(pl_addr), .pl_strobe(pl_strobe)
    );

    // Behavioural reference: one bit at a time, integers only.
    function automatic logic [31:0] model();
        logic [31:0] r = '0;
        int d = cpu_data;
        int rs = ((d >> cfg_rot) | (d << (8 - cfg_rot))) & 255;
        for (int p = 0; p < 4; p++) begin
            for (int b = 0; b < 8; b++) begin
                int lb = latch_in[p*8+b];
                int sb;
                int fb;
                int mb = cfg_bitmask[b];
                if (cfg_wmode == 1) begin
                    r[p*8+b] = lb[0];
                    continue;
                end
                if (cfg_wmode == 0) sb = cfg_const_en[p] ? cfg_const[p] : (rs >> b) & 1;
                else if (cfg_wmode == 2) sb = cpu_data[p];
                else begin
                    sb = cfg_const[p];
                    mb = mb & ((rs >> b) & 1);
                end
                case (cfg_func)
                    0: fb = sb;
                    1: fb = sb & lb;
                    2: fb = sb | lb;
                    default: fb = sb ^ lb;
                endcase
                r[p*8+b] = mb ? fb[0] : lb[0];
            end
        end
        return r;
    endfunction

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", cur_tag, what, act, exp);
        end
    endtask

    // One clock: inputs already set at a falling edge; compare after the rise.
    task automatic tick(input string tag);
        if (!rst_n) begin
            exp_stb = 0; exp_we = 0; exp_data = 0; exp_addr = 0;
        end else begin
            exp_stb = cpu_wr;
            exp_we  = cpu_wr ? cfg_planemask : 4'h0;
            if (cpu_wr) begin
                exp_data = model();
                exp_addr = cpu_addr;
            end
        end
        @(posedge clk);
        @(negedge clk);
        cur_tag = tag;
        check("strobe", {31'd0, pl_strobe}, {31'd0, exp_stb});
        check("we", {28'd0, pl_we}, {28'd0, exp_we});
        check("data", pl_wdata, exp_data);
        check("addr", {16'd0, pl_addr}, {16'd0, exp_addr});
    endtask

    task automatic wr(input string tag, input logic [1:0] m, input logic [7:0] d,
                      input logic [2:0] r, input logic [1:0] f, input logic [7:0] bm,
                      input logic [3:0] k, input logic [3:0] ke, input logic [3:0] pm,
                      input logic [31:0] l);
        cpu_wr = 1; cpu_addr = cpu_addr + 16'h0101; cpu_data = d;
        cfg_wmode = m; cfg_rot = r; cfg_func = f; cfg_bitmask = bm;
        cfg_const = k; cfg_const_en = ke; cfg_planemask = pm; latch_in = l;
        tick(tag);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        latch_in = 32'hA5A5_5A5A; cpu_wr = 1;
        tick("R1");
        tick("R1");
        rst_n = 1; cpu_wr = 0;
        tick("R2");
        // R4: rotation in mode 0, full mask, pass
        wr("R4", 2'd0, 8'h81, 3'd1, 2'd0, 8'hFF, 4'h0, 4'h0, 4'hF, 32'h0);
        wr("R4", 2'd0, 8'h3C, 3'd7, 2'd0, 8'hFF, 4'h0, 4'h0, 4'hF, 32'h1234_5678);
        // R5: partial constant enables mix rotated and constant planes
        wr("R5", 2'd0, 8'hF0, 3'd4, 2'd0, 8'hFF, 4'b1010, 4'b0110, 4'hF, 32'h0);
        // R6: each logical function
        wr("R6", 2'd0, 8'hCC, 3'd0, 2'd1, 8'hFF, 4'h0, 4'h0, 4'hF, 32'hF0F0_AAAA);
        wr("R6", 2'd0, 8'hCC, 3'd0, 2'd2, 8'hFF, 4'h0, 4'h0, 4'hF, 32'hF0F0_AAAA);
        wr("R6", 2'd0, 8'hCC, 3'd0, 2'd3, 8'hFF, 4'h0, 4'h0, 4'hF, 32'hF0F0_AAAA);
        // R7: partial bit mask keeps latch bits
        wr("R7", 2'd0, 8'hFF, 3'd0, 2'd0, 8'h0F, 4'h0, 4'h0, 4'hF, 32'h0000_0000);
        wr("R7", 2'd2, 8'h05, 3'd0, 2'd3, 8'h3C, 4'h0, 4'h0, 4'hF, 32'h1111_EEEE);
        // R8: latch copy ignores mask, function and data
        wr("R8", 2'd1, 8'hFF, 3'd3, 2'd3, 8'h00, 4'hF, 4'hF, 4'hF, 32'hDEAD_BEEF);
        // R9: data bit n spread across plane n
        wr("R9", 2'd2, 8'h06, 3'd5, 2'd0, 8'hFF, 4'h0, 4'h0, 4'hF, 32'h0);
        // R10: rotated byte forms the mask, constant forms the data
        wr("R10", 2'd3, 8'h0F, 3'd2, 2'd0, 8'hFF, 4'b0101, 4'h0, 4'hF, 32'h0000_0000);
        wr("R10", 2'd3, 8'hAA, 3'd1, 2'd2, 8'hF0, 4'b1100, 4'hF, 4'hF, 32'h0F0F_0F0F);
        // R2: plane mask and idle
        wr("R2", 2'd0, 8'h55, 3'd0, 2'd0, 8'hFF, 4'h0, 4'h0, 4'b1001, 32'h0);
        cpu_wr = 0; tick("R2");
        // R3 and mixed modes back-to-back
        for (int i = 0; i < 400; i++) begin
            wr("R3", 2'($urandom), 8'($urandom), 3'($urandom), 2'($urandom), 8'($urandom),
               4'($urandom), 4'($urandom), 4'($urandom), $urandom);
            if (($urandom & 7) == 0) begin
                cpu_wr = 0; tick("R2");
            end
        end
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule